// File: doc/BRIEF.md
# Nibble-Serial Arithmetic Flag Generator

This unit adds two 8-bit operands and produces both the sum and an 8-bit flag byte describing the addition. The work is split over two sequential nibble steps. The low step adds the low halves and keeps four interim flags: low carry, low borrow, low-zero and low even-parity. The high step adds the high halves, uses those interim flags, and finishes the flag byte. Each flag is produced at the step that owns the bits it depends on.

The flag byte also reports borrows for a subtraction that is carried out as an addition of the negated subtrahend. The second operand is taken to be the two's complement of that subtrahend. The borrow flags then say whether the matching true subtraction would have borrowed.

When carry-in is requested, a first pass of two steps adds 1 to the first operand. The normal two-step addition of that incremented operand and the second operand follows. The carry-type flags of both passes are merged, and the result-type flags come from the final sum.

Top module: `nibble_flag_gen`

## Requirements
- R1: Flag bit positions are fixed: bit 7 carry C, bit 6 negative N, bit 5 zero Z, bit 4 parity P, bit 3 half carry H, bit 2 overflow O, bit 1 borrow B, bit 0 low borrow L. C is the carry out of bit 7, and N equals bit 7 of the sum.
- R2: Z is 1 exactly when the 8-bit sum is zero. P is 1 exactly when the sum holds an even number of ones.
- R3: H is the carry out of bit 3. O is the carry out of bit 6 XOR the carry out of bit 7.
- R4: The subtrahend is s = (256 - b) mod 256. B is 1 when a < s, compared unsigned. L is 1 when a[3:0] < ((16 - b[3:0]) mod 16). A subtrahend of zero therefore never borrows.
- R5: sum_o equals (a + b + carry-in) mod 256.
- R6: Without carry-in, busy_o is high for exactly two cycles after start is sampled, one cycle per nibble step. done_o rises in the cycle after the second step.
- R7: With carry-in, the operation takes four steps and done_o follows the fourth. The result-type flags N, Z, P and O come from the final addition. C, H, B and L are the OR of those flags over the increment pass (a + 1) and the final pass ((a + 1) mod 256 + b).
- R8: start_i, a_i, b_i and cin_i are ignored while busy_o is high. The result returned is that of the operands captured at start.
- R9: After reset, busy_o, done_o, sum_o and flags_o are all 0.
- R10: done_o is a single-cycle pulse. sum_o and flags_o hold their value until the next operation completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation; sampled only when idle |
| cin_i | input | 1 | Request the carry-in pre-pass |
| a_i | input | 8 | First (accumulator) operand |
| b_i | input | 8 | Second operand |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| sum_o | output | 8 | Sum of the last completed operation |
| flags_o | output | 8 | Flag byte of the last completed operation |

## Verification
The bench targets the places where nibble splitting goes wrong.

A second operand of zero must give no borrow even though the addition gives no carry. A design that derived B as the plain inverse of C would raise B here. Sums such as 0x7F + 0x01 and 0x80 + 0x80 separate the carry out of bit 6 from the carry out of bit 7. A wrong O would flip on one of them. Low nibbles that sum to exactly 16 expose a half carry or low-zero flag that was not carried into the high step.

Carry-in cases with a = 0xFF are included. There only the increment pass carries, so a design that kept just the final pass's flags would lose C and H. Extra start pulses are sent mid-operation: a design that reloaded its operands would return a wrong sum or stretch busy.

// File: rtl/nfg_pkg.sv
package nfg_pkg;
  localparam int FLAG_W = 8;
  localparam int F_C = 7;
  localparam int F_N = 6;
  localparam int F_Z = 5;
  localparam int F_P = 4;
  localparam int F_H = 3;
  localparam int F_O = 2;
  localparam int F_B = 1;
  localparam int F_L = 0;
  // flags merged by OR across the carry-in pre-pass
  localparam logic [FLAG_W-1:0] CARRY_MASK =
    (FLAG_W'(1) << F_C) | (FLAG_W'(1) << F_H) | (FLAG_W'(1) << F_B) | (FLAG_W'(1) << F_L);

  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_PRE_LO = 3'd1,
    S_PRE_HI = 3'd2,
    S_LO     = 3'd3,
    S_HI     = 3'd4
  } step_e;

  typedef struct packed {
    logic carry;
    logic borrow;
    logic zero;
    logic even;
  } lo_flags_t;
endpackage

// File: rtl/nfg_lo_step.sv
module nfg_lo_step #(
  parameter int NIB_W = 4
) (
  input  logic [NIB_W-1:0] x_i,
  input  logic [NIB_W-1:0] y_i,
  output logic [NIB_W-1:0] sum_o,
  output nfg_pkg::lo_flags_t flg_o
);
  logic [NIB_W:0] full;

  always_comb begin
    full         = {1'b0, x_i} + {1'b0, y_i};
    sum_o        = full[NIB_W-1:0];
    flg_o.carry  = full[NIB_W];
    // a nonzero addend nibble means a nonzero subtrahend nibble: borrow iff no carry
    flg_o.borrow = (y_i != '0) & ~full[NIB_W];
    flg_o.zero   = (full[NIB_W-1:0] == '0);
    flg_o.even   = ~^full[NIB_W-1:0];
  end
endmodule

// File: rtl/nfg_hi_step.sv
module nfg_hi_step #(
  parameter int NIB_W = 4
) (
  input  logic [NIB_W-1:0]            x_i,
  input  logic [NIB_W-1:0]            y_i,
  input  nfg_pkg::lo_flags_t          lo_i,
  output logic [NIB_W-1:0]            sum_o,
  output logic [nfg_pkg::FLAG_W-1:0]  flags_o
);
  import nfg_pkg::*;

  logic [NIB_W:0]   full;
  logic [NIB_W-1:0] part;
  logic             c_top;
  logic             c_sub;
  logic             y_nz;

  always_comb begin
    full  = {1'b0, x_i} + {1'b0, y_i} + {{NIB_W{1'b0}}, lo_i.carry};
    // carry into the top bit from the bits below it
    part  = {1'b0, x_i[NIB_W-2:0]} + {1'b0, y_i[NIB_W-2:0]} + {{(NIB_W-1){1'b0}}, lo_i.carry};
    c_top = full[NIB_W];
    c_sub = part[NIB_W-1];
    // low addend nibble nonzero <=> low carry or low borrow was raised
    y_nz  = (y_i != '0) | lo_i.carry | lo_i.borrow;
    sum_o = full[NIB_W-1:0];
    flags_o      = '0;
    flags_o[F_C] = c_top;
    flags_o[F_N] = full[NIB_W-1];
    flags_o[F_Z] = lo_i.zero & (full[NIB_W-1:0] == '0);
    flags_o[F_P] = lo_i.even ^ (^full[NIB_W-1:0]);
    flags_o[F_H] = lo_i.carry;
    flags_o[F_O] = c_sub ^ c_top;
    flags_o[F_B] = y_nz & ~c_top;
    flags_o[F_L] = lo_i.borrow;
  end
endmodule

// File: rtl/nfg_ctrl.sv
module nfg_ctrl (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             cin_i,
  output nfg_pkg::step_e   step_o,
  output logic             busy_o,
  output logic             done_o
);
  import nfg_pkg::*;

  step_e step_q, step_d;
  logic  done_q;

  always_comb begin
    step_d = step_q;
    unique case (step_q)
      S_IDLE:   if (start_i) step_d = cin_i ? S_PRE_LO : S_LO;
      S_PRE_LO: step_d = S_PRE_HI;
      S_PRE_HI: step_d = S_LO;
      S_LO:     step_d = S_HI;
      S_HI:     step_d = S_IDLE;
      default:  step_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= S_IDLE;
      done_q <= 1'b0;
    end else begin
      step_q <= step_d;
      done_q <= (step_q == S_HI);
    end
  end

  assign step_o = step_q;
  assign busy_o = (step_q != S_IDLE);
  assign done_o = done_q;

  // R6
  hi_then_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_q == S_HI) |=> (done_q && step_q == S_IDLE));
  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  // R8
  lo_ignores_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_q == S_LO) |=> (step_q == S_HI));
endmodule

// File: rtl/nibble_flag_gen.sv
module nibble_flag_gen #(
  parameter int NIB_W  = 4,
  localparam int DATA_W = 2 * NIB_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              cin_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] sum_o,
  output logic [7:0]        flags_o
);
  import nfg_pkg::*;

  step_e             step;
  logic [DATA_W-1:0] a_q, b_q, y_op;
  logic [NIB_W-1:0]  lo_sum, lo_sum_q, hi_sum;
  lo_flags_t         lo_flg, lo_flg_q;
  logic [FLAG_W-1:0] hi_flags, acc_q, flags_q;
  logic [DATA_W-1:0] sum_q;
  logic              pre;

  nfg_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .cin_i   (cin_i),
    .step_o  (step),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  assign pre  = (step == S_PRE_LO) || (step == S_PRE_HI);
  assign y_op = pre ? DATA_W'(1) : b_q;

  nfg_lo_step #(.NIB_W(NIB_W)) u_lo (
    .x_i   (a_q[NIB_W-1:0]),
    .y_i   (y_op[NIB_W-1:0]),
    .sum_o (lo_sum),
    .flg_o (lo_flg)
  );

  nfg_hi_step #(.NIB_W(NIB_W)) u_hi (
    .x_i     (a_q[DATA_W-1:NIB_W]),
    .y_i     (y_op[DATA_W-1:NIB_W]),
    .lo_i    (lo_flg_q),
    .sum_o   (hi_sum),
    .flags_o (hi_flags)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q      <= '0;
      b_q      <= '0;
      lo_sum_q <= '0;
      lo_flg_q <= '0;
      acc_q    <= '0;
      sum_q    <= '0;
      flags_q  <= '0;
    end else begin
      unique case (step)
        S_IDLE: if (start_i) begin
          a_q   <= a_i;
          b_q   <= b_i;
          acc_q <= '0;
        end
        S_PRE_LO, S_LO: begin
          lo_sum_q <= lo_sum;
          lo_flg_q <= lo_flg;
        end
        S_PRE_HI: begin
          a_q   <= {hi_sum, lo_sum_q};
          acc_q <= hi_flags & CARRY_MASK;
        end
        S_HI: begin
          sum_q   <= {hi_sum, lo_sum_q};
          flags_q <= hi_flags | acc_q;
        end
        default: ;
      endcase
    end
  end

  assign sum_o   = sum_q;
  assign flags_o = flags_q;

  // R4
  no_carry_and_borrow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step == S_HI) |-> !(hi_flags[F_B] && hi_flags[F_C]));
  // R1
  neg_matches_msb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (flags_o[F_N] == sum_o[DATA_W-1]));
  // R2
  zero_matches_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (flags_o[F_Z] == (sum_o == '0)));
  // R8
  operand_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(b_q));
  // R10
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(busy_o) || busy_o) |-> $stable(flags_o));
endmodule

// File: tb/tb_nibble_flag_gen.sv
module tb_nibble_flag_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       cin = 1'b0;
  logic [7:0] a = '0, b = '0;
  logic       busy, done;
  logic [7:0] sum, flags;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  nibble_flag_gen dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cin_i(cin),
    .a_i(a), .b_i(b), .busy_o(busy), .done_o(done), .sum_o(sum), .flags_o(flags)
  );

  function automatic logic [7:0] pass_flags(int x, int y);
    int s, r, c, sub;
    logic [7:0] f;
    s = x + y; c = s / 256; r = s % 256; sub = (256 - y) % 256;
    f = '0;
    f[7] = (c != 0);
    f[6] = (r >= 128);
    f[5] = (r == 0);
    f[4] = ($countones(8'(r)) % 2) == 0;
    f[3] = ((x % 16) + (y % 16)) >= 16;
    f[2] = ((((x % 128) + (y % 128)) >= 128) != (c != 0));
    f[1] = (x < sub);
    f[0] = ((x % 16) < ((16 - (y % 16)) % 16));
    return f;
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic run_op(int xa, int xb, bit xc, bit poke);
    int steps, esum;
    logic [7:0] ef, f1, f2;
    steps = xc ? 4 : 2;
    esum = (xa + xb + (xc ? 1 : 0)) % 256;
    if (xc) begin
      f1 = pass_flags(xa, 1);
      f2 = pass_flags((xa + 1) % 256, xb);
      ef = f2 | (f1 & 8'h8B);
    end else begin
      ef = pass_flags(xa, xb);
    end
    @(negedge clk);
    a = 8'(xa); b = 8'(xb); cin = xc; start = 1'b1;
    for (int i = 0; i < steps; i++) begin
      @(negedge clk);
      if (poke && i == 0) begin
        start = 1'b1; a = ~a; b = b + 8'd37; cin = ~cin;
      end else start = 1'b0;
      check("R6 busy", busy, 1);
      check("R6 done early", done, 0);
    end
    @(negedge clk);
    start = 1'b0;
    check("R6 busy end", busy, 0);
    check("R6 done", done, 1);
    check(poke ? "R8 sum" : "R5 sum", sum, esum);
    check(xc ? "R7 flags" : "R1 R2 R3 R4 flags", flags, ef);
    @(negedge clk);
    check("R10 pulse", done, 0);
    check("R10 hold", flags, ef);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    finish_up();
  end

  always @(posedge clk) cyc++;

  initial begin
    int lf;
    repeat (3) @(negedge clk);
    check("R9 busy", busy, 0);
    check("R9 done", done, 0);
    check("R9 sum", sum, 0);
    check("R9 flags", flags, 0);
    rst_n = 1'b1;
    // R1 R5 basic patterns
    run_op(8'h00, 8'h00, 0, 0);
    run_op(8'hFF, 8'h01, 0, 0);
    // R3 overflow cases
    run_op(8'h7F, 8'h01, 0, 0);
    run_op(8'h80, 8'h80, 0, 0);
    run_op(8'h0F, 8'h01, 0, 0);
    run_op(8'h10, 8'hF0, 0, 0);
    // R4 zero subtrahend never borrows
    run_op(8'h05, 8'h00, 0, 0);
    run_op(8'h03, 8'hFB, 0, 0);
    run_op(8'h38, 8'h08, 0, 0);
    // R7 carry-in
    run_op(8'hFF, 8'h00, 1, 0);
    run_op(8'h0F, 8'h10, 1, 0);
    run_op(8'h7E, 8'h00, 1, 0);
    run_op(8'h00, 8'h00, 1, 0);
    // R8 start ignored while busy
    run_op(8'h12, 8'h34, 0, 1);
    run_op(8'hA5, 8'h5A, 1, 1);
    lf = 32'h1ACE;
    for (int k = 0; k < 400; k++) begin
      lf = (lf * 1103515245 + 12345) & 32'h7FFFFFFF;
      run_op((lf >> 8) % 256, (lf >> 16) % 256, lf[3], lf[5:4] == 2'b11);
    end
    finish_up();
  end
endmodule